// File: doc/BRIEF.md
# Two-Level I/O Address Table Walker

This block turns a 32-bit I/O virtual address into a physical address by walking a two-level translation table held in memory. A requester presents an address and a master number on the translation port. The walker reads a first-level entry from the table whose base comes from the `table_base` input, checks that entry, then reads the second-level entry it points to and checks that one too. It answers with the physical address and the four-bit authority index, or with a fault. The walker handles one translation at a time and reads memory through a plain request/response read port.

Faults are logged per level. A bad first-level entry and a bad second-level entry each have their own sticky status bit, their own captured fault address and their own per-master blame vector. A one-cycle `flt_clr` pulse clears the status bits and blame vectors. When `enable` is low at acceptance, the walk is skipped and the input address is returned unchanged.

The state machine has seven states:
- IDLE: ready for a request.
- L1_ISSUE: first-level read issued.
- L1_WAIT: waiting for the first-level data.
- L2_ISSUE: second-level read issued.
- L2_WAIT: waiting for the second-level data.
- DONE: successful response.
- FAULT: fault response.

The transitions are:
- accept: IDLE to L1_ISSUE when enabled, or IDLE to DONE when bypassed.
- issue: L1_ISSUE to L1_WAIT, and L2_ISSUE to L2_WAIT.
- l1_ok: L1_WAIT to L2_ISSUE.
- l1_bad: L1_WAIT to FAULT.
- l2_ok: L2_WAIT to DONE.
- l2_bad: L2_WAIT to FAULT.
- retire: DONE or FAULT back to IDLE.

Top module: `iova_table_walker`

## Requirements
- R1: After reset the walker is idle. `req_ready` is 1, `rsp_valid` and `mem_rd_valid` are 0, and `flt_status`, both fault addresses and both blame vectors are 0.
- R2: One cycle after an enabled request is accepted, the walker pulses `mem_rd_valid` for one cycle. The read address is `table_base + vaddr[31:20]*4`.
- R3: A first-level entry is valid only when its bits 1:0 equal 2'b01. For a valid entry, the next read goes to `{entry[31:10],10'b0} + vaddr[19:12]*4`. Entry bits 9:2 are ignored.
- R4: A second-level entry is valid when its bit 1 is set. Then `rsp_paddr = {entry[31:12], vaddr[11:0]}`, `rsp_aci = entry[7:4]` and `rsp_fault = 2'b00`. Entry bits 11:8, 3:2 and 0 are ignored.
- R5: An invalid first-level entry ends the walk with no second read. The response carries `rsp_fault = 2'b01` with `rsp_paddr` and `rsp_aci` 0. It also sets `flt_status[16]`, loads `flt_l1_addr` with the virtual address, and sets bit `master` of `flt_l1_blame`.
- R6: An invalid second-level entry ends the walk with `rsp_fault = 2'b10` and `rsp_paddr`/`rsp_aci` 0. It also sets `flt_status[17]`, loads `flt_l2_addr` with the virtual address, and sets bit `master` of `flt_l2_blame`.
- R7: Blame bits accumulate across faults until cleared. A fault address always holds the latest fault of its level. A `flt_clr` pulse clears both status bits and both blame vectors.
- R8: If `enable` is 0 when a request is accepted, no memory read is made. The response comes the cycle after acceptance with `rsp_paddr = vaddr`, `rsp_aci = 0` and `rsp_fault = 0`.
- R9: `req_ready` is 1 only in IDLE. A request presented while `req_ready` is 0 has no effect on reads, responses or fault logs.
- R10: `rsp_valid` is a one-cycle pulse. It comes in the cycle after the memory response that ends the walk. The walker is ready again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Translation on; low means pass-through |
| table_base | input | 32 | Byte address of the first-level table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_addr | input | 32 | Virtual address |
| req_master | input | 3 | Number of the requesting master |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_aci | output | 4 | Authority index (0 on fault or bypass) |
| rsp_fault | output | 2 | bit0 first-level fault, bit1 second-level fault |
| mem_rd_valid | output | 1 | Memory read request pulse |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |
| flt_clr | input | 1 | Clears fault status bits and blame vectors |
| flt_status | output | 32 | bit16 first-level fault seen, bit17 second-level fault seen |
| flt_l1_addr | output | 32 | Address of the latest first-level fault |
| flt_l2_addr | output | 32 | Address of the latest second-level fault |
| flt_l1_blame | output | 6 | Masters that hit a first-level fault |
| flt_l2_blame | output | 6 | Masters that hit a second-level fault |

## Verification
The bench aims at the first-level validity code. It uses entries ending in 2'b11, 2'b10 and 2'b00. A walker that tested only bit 0 would go on to a second read instead of faulting. It uses a first-level entry with its reserved bits 9:2 all set: a design that kept them in the table pointer would read the wrong second-level address. A second-level entry has its low bit set while bit 1 is clear; a design that looked at the wrong bit would return a translation instead of a fault. Memory latencies of one and three cycles, with a second request held during the walk, expose response timing that is off by a cycle and walks that restart. Faults from two masters followed by a clear expose blame vectors that overwrite instead of accumulating, or that do not clear.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int VA_W        = 32;
    localparam int PAGE_W      = 12;
    localparam int L1_IDX_LSB  = 20;
    localparam int L2_IDX_LSB  = 12;
    localparam int PT_ALIGN_W  = 10;
    localparam int ACI_W       = 4;
    localparam int STAT_L1_BIT = 16;
    localparam int STAT_L2_BIT = 17;
    localparam int N_LEVELS    = 2;
    localparam logic [1:0] L1_VALID_CODE = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_ISSUE,
        ST_L1_WAIT,
        ST_L2_ISSUE,
        ST_L2_WAIT,
        ST_DONE,
        ST_FAULT
    } walk_state_e;
endpackage

// File: rtl/xw_entry_dec.sv
module xw_entry_dec
    import xw_pkg::*;
(
    input  logic [VA_W-1:0]   entry,
    output logic              l1_ok,
    output logic [VA_W-1:0]   l1_pt_base,
    output logic              l2_ok,
    output logic [VA_W-PAGE_W-1:0] l2_page,
    output logic [ACI_W-1:0]  l2_aci
);
    logic unused_rsvd;

    always_comb begin
        l1_ok      = (entry[1:0] == L1_VALID_CODE);
        l1_pt_base = {entry[VA_W-1:PT_ALIGN_W], {PT_ALIGN_W{1'b0}}};
        l2_ok      = entry[1];
        l2_page    = entry[VA_W-1:PAGE_W];
        l2_aci     = entry[7:4];
        unused_rsvd = ^{entry[9:8], entry[3:2]};
    end
endmodule

// File: rtl/xw_fault_log.sv
module xw_fault_log
    import xw_pkg::*;
#(
    parameter int N_MASTERS = 6,
    localparam int MID_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt,
    input  logic [VA_W-1:0]      evt_addr,
    input  logic [MID_W-1:0]     evt_master,
    input  logic                 clr,
    output logic                 flag,
    output logic [VA_W-1:0]      addr,
    output logic [N_MASTERS-1:0] blame
);
    logic [N_MASTERS-1:0] hit;

    always_comb hit = N_MASTERS'(1) << evt_master;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            addr  <= '0;
            blame <= '0;
        end else if (evt) begin
            flag  <= 1'b1;
            addr  <= evt_addr;
            blame <= (clr ? '0 : blame) | hit;
        end else if (clr) begin
            flag  <= 1'b0;
            blame <= '0;
        end
    end

    // R5/R6: a fault event is logged on the next cycle
    p_evt_logged_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (flag && addr == $past(evt_addr) && blame[$past(evt_master)]));

    // R7: a clear with no new fault empties the log
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> (!flag && blame == '0));

    // R7: with no event and no clear the blame vector never loses bits
    p_blame_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !evt) |=> ((blame & $past(blame)) == $past(blame)));
endmodule

// File: rtl/xw_walk_fsm.sv
module xw_walk_fsm
    import xw_pkg::*;
#(
    parameter int N_MASTERS = 6,
    localparam int MID_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic [VA_W-1:0]         table_base,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [VA_W-1:0]         req_addr,
    input  logic [MID_W-1:0]        req_master,
    output logic                    rsp_valid,
    output logic [VA_W-1:0]         rsp_paddr,
    output logic [ACI_W-1:0]        rsp_aci,
    output logic [N_LEVELS-1:0]     rsp_fault,
    output logic                    mem_rd_valid,
    output logic [VA_W-1:0]         mem_rd_addr,
    input  logic                    mem_rsp_valid,
    input  logic                    l1_ok,
    input  logic [VA_W-1:0]         l1_pt_base,
    input  logic                    l2_ok,
    input  logic [VA_W-PAGE_W-1:0]  l2_page,
    input  logic [ACI_W-1:0]        l2_aci,
    output logic [N_LEVELS-1:0]     lvl_evt,
    output logic [VA_W-1:0]         evt_addr,
    output logic [MID_W-1:0]        evt_master
);
    walk_state_e state_q, state_d;

    logic [VA_W-1:0]     va_q;
    logic [MID_W-1:0]    mst_q;
    logic [VA_W-1:0]     rd_addr_q;
    logic [VA_W-1:0]     paddr_q;
    logic [ACI_W-1:0]    aci_q;
    logic [N_LEVELS-1:0] fault_q;

    logic accept;
    logic l1_back;
    logic l2_back;

    always_comb begin
        accept  = req_valid && (state_q == ST_IDLE);
        l1_back = mem_rsp_valid && (state_q == ST_L1_WAIT);
        l2_back = mem_rsp_valid && (state_q == ST_L2_WAIT);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = enable ? ST_L1_ISSUE : ST_DONE;
            ST_L1_ISSUE: state_d = ST_L1_WAIT;
            ST_L1_WAIT:  if (mem_rsp_valid) state_d = l1_ok ? ST_L2_ISSUE : ST_FAULT;
            ST_L2_ISSUE: state_d = ST_L2_WAIT;
            ST_L2_WAIT:  if (mem_rsp_valid) state_d = l2_ok ? ST_DONE : ST_FAULT;
            ST_DONE:     state_d = ST_IDLE;
            ST_FAULT:    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q      <= '0;
            mst_q     <= '0;
            rd_addr_q <= '0;
            paddr_q   <= '0;
            aci_q     <= '0;
            fault_q   <= '0;
        end else begin
            if (accept) begin
                va_q      <= req_addr;
                mst_q     <= req_master;
                rd_addr_q <= table_base + VA_W'({req_addr[VA_W-1:L1_IDX_LSB], 2'b00});
                paddr_q   <= req_addr;
                aci_q     <= '0;
                fault_q   <= '0;
            end
            if (l1_back) begin
                if (l1_ok) begin
                    rd_addr_q <= l1_pt_base + VA_W'({va_q[L1_IDX_LSB-1:L2_IDX_LSB], 2'b00});
                end else begin
                    fault_q <= 2'b01;
                    paddr_q <= '0;
                end
            end
            if (l2_back) begin
                if (l2_ok) begin
                    paddr_q <= {l2_page, va_q[PAGE_W-1:0]};
                    aci_q   <= l2_aci;
                end else begin
                    fault_q <= 2'b10;
                    paddr_q <= '0;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        mem_rd_valid = (state_q == ST_L1_ISSUE) || (state_q == ST_L2_ISSUE);
        mem_rd_addr  = rd_addr_q;
        rsp_valid    = (state_q == ST_DONE) || (state_q == ST_FAULT);
        rsp_paddr    = paddr_q;
        rsp_aci      = aci_q;
        rsp_fault    = fault_q;
        lvl_evt[0]   = l1_back && !l1_ok;
        lvl_evt[1]   = l2_back && !l2_ok;
        evt_addr     = va_q;
        evt_master   = mst_q;
    end

    // R2: read requests are single-cycle pulses
    p_rd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !mem_rd_valid);

    // R9: an idle walker neither reads nor responds
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_valid && !rsp_valid));

    // R10: a response lasts one cycle and the walker is ready after it
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R5/R6: at most one fault kind, and a faulting response carries no address
    p_fault_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(rsp_fault) <= 1 &&
                       (rsp_fault == '0 || (rsp_paddr == '0 && rsp_aci == '0))));
endmodule

// File: rtl/iova_table_walker.sv
module iova_table_walker
    import xw_pkg::*;
#(
    parameter int N_MASTERS = 6,
    localparam int MID_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [31:0]          table_base,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [31:0]          req_addr,
    input  logic [MID_W-1:0]     req_master,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_paddr,
    output logic [3:0]           rsp_aci,
    output logic [1:0]           rsp_fault,
    output logic                 mem_rd_valid,
    output logic [31:0]          mem_rd_addr,
    input  logic                 mem_rsp_valid,
    input  logic [31:0]          mem_rsp_data,
    input  logic                 flt_clr,
    output logic [31:0]          flt_status,
    output logic [31:0]          flt_l1_addr,
    output logic [31:0]          flt_l2_addr,
    output logic [N_MASTERS-1:0] flt_l1_blame,
    output logic [N_MASTERS-1:0] flt_l2_blame
);
    logic                   l1_ok, l2_ok;
    logic [VA_W-1:0]        l1_pt_base;
    logic [VA_W-PAGE_W-1:0] l2_page;
    logic [ACI_W-1:0]       l2_aci;
    logic [N_LEVELS-1:0]    lvl_evt;
    logic [VA_W-1:0]        evt_addr;
    logic [MID_W-1:0]       evt_master;

    logic [N_LEVELS-1:0]                lv_flag;
    logic [N_LEVELS-1:0][VA_W-1:0]      lv_addr;
    logic [N_LEVELS-1:0][N_MASTERS-1:0] lv_blame;

    xw_entry_dec u_dec (
        .entry      (mem_rsp_data),
        .l1_ok      (l1_ok),
        .l1_pt_base (l1_pt_base),
        .l2_ok      (l2_ok),
        .l2_page    (l2_page),
        .l2_aci     (l2_aci)
    );

    xw_walk_fsm #(.N_MASTERS(N_MASTERS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .table_base    (table_base),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_master    (req_master),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_aci       (rsp_aci),
        .rsp_fault     (rsp_fault),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .l1_ok         (l1_ok),
        .l1_pt_base    (l1_pt_base),
        .l2_ok         (l2_ok),
        .l2_page       (l2_page),
        .l2_aci        (l2_aci),
        .lvl_evt       (lvl_evt),
        .evt_addr      (evt_addr),
        .evt_master    (evt_master)
    );

    for (genvar lv = 0; lv < N_LEVELS; lv++) begin : g_log
        xw_fault_log #(.N_MASTERS(N_MASTERS)) u_log (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt        (lvl_evt[lv]),
            .evt_addr   (evt_addr),
            .evt_master (evt_master),
            .clr        (flt_clr),
            .flag       (lv_flag[lv]),
            .addr       (lv_addr[lv]),
            .blame      (lv_blame[lv])
        );
    end

    always_comb begin
        flt_status              = '0;
        flt_status[STAT_L1_BIT] = lv_flag[0];
        flt_status[STAT_L2_BIT] = lv_flag[1];
        flt_l1_addr             = lv_addr[0];
        flt_l2_addr             = lv_addr[1];
        flt_l1_blame            = lv_blame[0];
        flt_l2_blame            = lv_blame[1];
    end
endmodule

// File: tb/tb_iova_table_walker.sv
module tb_iova_table_walker;
    localparam int NM = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic [31:0] table_base = 32'h0004_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_master = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [3:0]  rsp_aci;
    logic [1:0]  rsp_fault;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        flt_clr = 1'b0;
    logic [31:0] flt_status, flt_l1_addr, flt_l2_addr;
    logic [NM-1:0] flt_l1_blame, flt_l2_blame;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #5ns clk = ~clk;

    iova_table_walker #(.N_MASTERS(NM)) dut (.*);

    // behavioural memory and expected fault log
    logic [31:0] mem_img [logic [31:0]];
    logic [31:0] rd_log[$];
    int lat = 1;
    int cnt = 0;
    logic [31:0] pend_addr = '0;
    logic        e_flag [2];
    logic [31:0] e_faddr [2];
    logic [NM-1:0] e_blame [2];

    function automatic logic [31:0] peek(input logic [31:0] a);
        return mem_img.exists(a) ? mem_img[a] : 32'h0;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory responder: fixed latency in negedges
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = peek(pend_addr);
                end
            end
            if (mem_rd_valid) begin
                cnt = lat;
                pend_addr = mem_rd_addr;
                rd_log.push_back(mem_rd_addr);
            end
        end
    end

    task automatic check_log(input string req);
        chk(req, "l1 status bit16", 32'(flt_status[16]), 32'(e_flag[0]));
        chk(req, "l2 status bit17", 32'(flt_status[17]), 32'(e_flag[1]));
        chk(req, "l1 fault addr", flt_l1_addr, e_faddr[0]);
        chk(req, "l2 fault addr", flt_l2_addr, e_faddr[1]);
        chk(req, "l1 blame", 32'(flt_l1_blame), 32'(e_blame[0]));
        chk(req, "l2 blame", 32'(flt_l2_blame), 32'(e_blame[1]));
    endtask

    // one translation against the model; junk holds a request during the walk
    task automatic xlate(input string req, input logic [31:0] va, input int m,
                         input logic en, input bit junk);
        logic [31:0] l1a, l2a, e1, e2, x_pa;
        logic [3:0]  x_aci;
        logic [1:0]  x_flt;
        int x_k;
        logic [31:0] x_rd[$];
        l1a = table_base + {18'd0, va[31:20], 2'b00};
        e1 = peek(l1a);
        l2a = {e1[31:10], 10'd0} + {22'd0, va[19:12], 2'b00};
        e2 = peek(l2a);
        x_rd = {};
        if (!en) begin
            x_k = 1; x_pa = va; x_aci = 0; x_flt = 0;
        end else if (e1[1:0] != 2'b01) begin
            x_k = lat + 2; x_pa = 0; x_aci = 0; x_flt = 2'b01;
            x_rd.push_back(l1a);
        end else if (!e2[1]) begin
            x_k = 2*lat + 3; x_pa = 0; x_aci = 0; x_flt = 2'b10;
            x_rd.push_back(l1a); x_rd.push_back(l2a);
        end else begin
            x_k = 2*lat + 3; x_pa = {e2[31:12], va[11:0]}; x_aci = e2[7:4]; x_flt = 0;
            x_rd.push_back(l1a); x_rd.push_back(l2a);
        end
        rd_log = {};
        @(negedge clk);
        chk("R9", "ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = va; req_master = 3'(m); enable = en;
        for (int k = 1; k <= x_k + 1; k++) begin
            @(negedge clk);
            if (k == 1) begin
                if (junk) req_addr = 32'hFFFF_F000; else req_valid = 1'b0;
                req_master = 3'd5;
                chk("R9", "busy after accept", 32'(req_ready), 32'd0);
            end
            if (k == x_k) req_valid = 1'b0;
            if (k < x_k && rsp_valid) chk("R10", "early response", 32'(rsp_valid), 32'd0);
            if (k == x_k) begin
                chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
                chk(req, "rsp_paddr", rsp_paddr, x_pa);
                chk(req, "rsp_aci", 32'(rsp_aci), 32'(x_aci));
                chk(req, "rsp_fault", 32'(rsp_fault), 32'(x_flt));
            end
            if (k == x_k + 1) begin
                chk("R10", "response is a pulse", 32'(rsp_valid), 32'd0);
                chk("R10", "ready after response", 32'(req_ready), 32'd1);
            end
        end
        chk(req, "read count", 32'(rd_log.size()), 32'(x_rd.size()));
        for (int i = 0; i < x_rd.size() && i < rd_log.size(); i++)
            chk(i == 0 ? "R2" : "R3", "read address", rd_log[i], x_rd[i]);
        for (int lv = 0; lv < 2; lv++) begin
            if (x_flt[lv]) begin
                e_flag[lv] = 1'b1; e_faddr[lv] = va; e_blame[lv][m] = 1'b1;
            end
        end
        check_log(x_flt[1] ? "R6" : (x_flt[0] ? "R5" : req));
    endtask

    initial begin
        for (int lv = 0; lv < 2; lv++) begin
            e_flag[lv] = 0; e_faddr[lv] = 0; e_blame[lv] = 0;
        end
        // valid walk: L1 entry with reserved bits 9:2 set
        mem_img[32'h0004_048C] = 32'h0080_03FD;
        // L2 entry with reserved bits 11:8 and bit 0 set, aci 5
        mem_img[32'h0080_0114] = 32'hABCD_EF53;
        // L2 entry invalid (bit1 clear, bit0 set)
        mem_img[32'h0080_0224] = 32'h1234_50F1;
        // L1 entries with bad codes 11 and 10
        mem_img[32'h0004_000C] = 32'h0090_0003;
        mem_img[32'h0004_0018] = 32'h0090_0002;
        mem_img[32'h0090_0000] = 32'hFFFF_F0F2;
        // second valid table with aci 0xA
        mem_img[32'h0004_0100] = 32'h00A0_0401;
        mem_img[32'h00A0_07FC] = 32'h5555_50A2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "req_ready", 32'(req_ready), 32'd1);
        chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1", "mem_rd_valid", 32'(mem_rd_valid), 32'd0);
        check_log("R1");

        lat = 1;
        xlate("R4", 32'h1234_5678, 0, 1'b1, 1'b0);   // R3 reserved bits ignored
        xlate("R5", 32'h0030_0ABC, 2, 1'b1, 1'b0);   // code 11
        xlate("R6", 32'h1238_9ABC, 1, 1'b1, 1'b1);   // L2 invalid, junk held
        xlate("R8", 32'hDEAD_BEEF, 3, 1'b0, 1'b0);   // bypass
        lat = 3;
        xlate("R5", 32'h0060_0001, 4, 1'b1, 1'b1);   // code 10, blame accumulates R7
        xlate("R5", 32'h0050_0000, 4, 1'b1, 1'b0);   // code 00 (empty entry)
        xlate("R4", 32'h040F_F123, 5, 1'b1, 1'b1);   // second table, last index
        xlate("R6", 32'h1238_9000, 0, 1'b1, 1'b0);   // R7 second L2 fault overwrites address

        // R7 clear
        @(negedge clk); flt_clr = 1'b1;
        @(negedge clk); flt_clr = 1'b0;
        for (int lv = 0; lv < 2; lv++) begin
            e_flag[lv] = 0; e_blame[lv] = 0;
        end
        check_log("R7");
        lat = 2;
        xlate("R8", 32'h0000_0FFF, 1, 1'b0, 1'b1);
        xlate("R4", 32'h1234_5000, 2, 1'b1, 1'b0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule